// File: doc/BRIEF.md
# Dual-Edge Bit-Serial Adder

This block adds two unsigned words that arrive one bit at a time, least significant bit first. It returns one sum bit on every clock edge, rising and falling, so a word finishes in half the clock cycles a single-edge serial adder would need. Two full-adder slices split the work. The even slice handles bit positions 0, 2, … and is registered on the rising edge. The odd slice handles positions 1, 3, … and is registered on the falling edge. Each slice's carry register feeds the other slice on the next edge.

A caller raises `word_start` together with bit 0 ahead of a rising edge. It then presents one operand bit pair before each following edge. The serial sum is read on `sum_bit`, where the clock level selects between the two edge domains: the even result while the clock is high, the odd result while it is low. Because each half-period carries one bit, the clock must have a 50% duty cycle. The carry left after the top bit is held on `carry_out` until the next word completes. Words may follow each other with no gap.

Top module: `dual_edge_serial_adder`

## Requirements
- R1: With `rst_n` low at a rising edge, `carry_out` and the even sum register clear to 0. With `rst_n` low at a falling edge, the odd sum register clears to 0.
- R2: Operand bits at even positions (0, 2, …) are sampled on rising edges. Their sum bit appears on `sum_bit` during the following clock-high phase.
- R3: Operand bits at odd positions (1, 3, …) are sampled on falling edges. Their sum bit appears on `sum_bit` during the following clock-low phase.
- R4: The carry from the even slice is the carry-in of the odd slice at the next falling edge. The carry from the odd slice is the carry-in of the even slice at the next rising edge.
- R5: `word_start` high at a rising edge forces the carry-in of bit 0 to 0, whatever the previous word left behind.
- R6: The carry out of the top bit appears on `carry_out` at the first rising edge after the word's last falling edge. It stays unchanged until the next word's final carry is captured, including over idle cycles with `word_start` low.
- R7: Words may be issued back to back, one every WORD_BITS/2 clock cycles. Each word's sum bits are the low WORD_BITS bits of the integer sum, and its `carry_out` is bit WORD_BITS of that sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 50% duty cycle; both edges are active |
| rst_n | input | 1 | Synchronous active-low reset |
| word_start | input | 1 | High with bit 0 ahead of a rising edge to begin a word |
| op_a | input | 1 | Serial operand A, LSB first |
| op_b | input | 1 | Serial operand B, LSB first |
| sum_bit | output | 1 | Serial sum; even-slice result while clk high, odd-slice result while clk low |
| carry_out | output | 1 | Final carry of the last completed word |

## Verification
When words run back to back, one rising edge does two jobs. It captures the previous word's final carry into `carry_out`, and it clears the carry-in for the next word's bit 0. The bench provokes this by streaming all 256 operand pairs with no gap. For every word it checks both the new word's low sum bit and the previous word's carry at that shared edge. Random words with random idle gaps then show that the carry is held while no word runs.

// File: rtl/dbsa_pkg.sv
// Shared types and the full-adder function used by both adder slices.
package dbsa_pkg;

    // Result of one bit position: sum bit and carry to the next position.
    typedef struct packed {
        logic sum;
        logic carry;
    } fa_res_t;

    // One-bit full addition.
    function automatic fa_res_t full_add(input logic a, input logic b, input logic cin);
        fa_res_t r;
        r.sum   = a ^ b ^ cin;
        r.carry = (a & b) | (a & cin) | (b & cin);
        return r;
    endfunction

endpackage

// File: rtl/dbsa_slice.sv
// One adder slice: a full adder followed by a sum/carry register.
// RISING_EDGE selects the clock edge the register uses.
// Assumes rst_n is synchronous and is sampled on the same edge as the register.
module dbsa_slice #(
    parameter bit RISING_EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_bit,
    input  logic b_bit,
    input  logic carry_in,
    output logic sum_q,
    output logic carry_q
);
    import dbsa_pkg::*;

    fa_res_t res;

    // Combinational add of the bits present at this slice's edge.
    always_comb res = full_add(a_bit, b_bit, carry_in);

    generate
        if (RISING_EDGE) begin : g_pos
            // Register the result on the rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sum_q   <= 1'b0;
                    carry_q <= 1'b0;
                end else begin
                    sum_q   <= res.sum;
                    carry_q <= res.carry;
                end
            end
        end else begin : g_neg
            // Register the result on the falling edge.
            always_ff @(negedge clk) begin
                if (!rst_n) begin
                    sum_q   <= 1'b0;
                    carry_q <= 1'b0;
                end else begin
                    sum_q   <= res.sum;
                    carry_q <= res.carry;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dbsa_word_ctrl.sv
// Word sequencing in the rising-edge domain. It tracks which bit pair is in
// progress, chooses the even slice's carry-in (0 on a start strobe) and
// captures the final carry once the word's last falling edge has passed.
// Assumes WORD_BITS is even and at least 2.
module dbsa_word_ctrl #(
    parameter int WORD_BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_start,
    input  logic carry_odd_q,
    output logic carry_even_in,
    output logic carry_out
);
    localparam int PAIRS  = WORD_BITS / 2;
    localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam logic [PAIR_W-1:0] LAST = PAIR_W'(PAIRS - 1);

    logic              active;
    logic [PAIR_W-1:0] pair_idx;

    // A start strobe breaks the carry chain so bit 0 gets a zero carry-in.
    assign carry_even_in = word_start ? 1'b0 : carry_odd_q;

    // Advance the pair counter and capture the final carry at word end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            pair_idx  <= '0;
            carry_out <= 1'b0;
        end else begin
            if (active && pair_idx == LAST) begin
                carry_out <= carry_odd_q;
            end
            if (word_start) begin
                active   <= 1'b1;
                pair_idx <= '0;
            end else if (active) begin
                if (pair_idx == LAST) begin
                    active <= 1'b0;
                end else begin
                    pair_idx <= PAIR_W'(pair_idx + 1'b1);
                end
            end
        end
    end

endmodule

// File: rtl/dbsa_phase_mux.sv
// Output multiplexer driven by the clock level: the rising-edge result is
// shown while the clock is high, the falling-edge result while it is low.
// Assumes a 50% duty cycle so each result is visible for half a period.
module dbsa_phase_mux (
    input  logic clk_level,
    input  logic even_bit,
    input  logic odd_bit,
    output logic y
);
    // Select by clock phase.
    always_comb y = clk_level ? even_bit : odd_bit;

endmodule

// File: rtl/dual_edge_serial_adder.sv
// Top level of the dual-edge bit-serial adder. The even slice registers on
// the rising edge and the odd slice on the falling edge. Their carries
// cross-couple, and a clock-level multiplexer merges their sums.
// Assumes a 50% duty cycle, operands LSB first, and word_start high with bit 0.
module dual_edge_serial_adder #(
    parameter int WORD_BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_start,
    input  logic op_a,
    input  logic op_b,
    output logic sum_bit,
    output logic carry_out
);
    logic sum_even_q, carry_even_q;
    logic sum_odd_q,  carry_odd_q;
    logic carry_even_in;

    dbsa_word_ctrl #(.WORD_BITS(WORD_BITS)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .word_start    (word_start),
        .carry_odd_q   (carry_odd_q),
        .carry_even_in (carry_even_in),
        .carry_out     (carry_out)
    );

    dbsa_slice #(.RISING_EDGE(1'b1)) u_even (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_bit    (op_a),
        .b_bit    (op_b),
        .carry_in (carry_even_in),
        .sum_q    (sum_even_q),
        .carry_q  (carry_even_q)
    );

    dbsa_slice #(.RISING_EDGE(1'b0)) u_odd (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_bit    (op_a),
        .b_bit    (op_b),
        .carry_in (carry_even_q),
        .sum_q    (sum_odd_q),
        .carry_q  (carry_odd_q)
    );

    dbsa_phase_mux u_out (
        .clk_level (clk),
        .even_bit  (sum_even_q),
        .odd_bit   (sum_odd_q),
        .y         (sum_bit)
    );

endmodule

// File: rtl/dbsa_checker.sv
// Assertion checker bound to the adder top. It keeps its own pair count
// from word_start to know when a final-carry capture is allowed.
module dbsa_checker #(
    parameter int WORD_BITS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic word_start,
    input logic op_a,
    input logic op_b,
    input logic sum_bit,
    input logic carry_out
);
    localparam int PAIRS = WORD_BITS / 2;
    localparam int CW    = $clog2(PAIRS + 1) + 1;

    logic [CW-1:0] cnt;
    logic          start_zero_q;

    // Count pairs in progress; value PAIRS marks the edge that captures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt          <= '0;
            start_zero_q <= 1'b0;
        end else begin
            start_zero_q <= word_start && !op_a && !op_b;
            if (word_start)
                cnt <= CW'(1);
            else if (cnt != '0 && cnt < CW'(PAIRS))
                cnt <= CW'(cnt + 1'b1);
            else
                cnt <= '0;
        end
    end

    // R1: a reset edge leaves carry_out at 0.
    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> !carry_out);

    // R6: carry_out only moves at a word-end capture edge.
    a_r6_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != CW'(PAIRS)) |=> $stable(carry_out));

    // R5: bit 0 with zero operands after a start gives a 0 sum in the high phase.
    a_r5_start_zero: assert property (@(negedge clk) disable iff (!rst_n)
        start_zero_q |-> !sum_bit);

    // R2: the high-phase sum is never unknown once out of reset.
    a_r2_sum_known: assert property (@(negedge clk) disable iff (!rst_n)
        !$isunknown(sum_bit));

endmodule

bind dual_edge_serial_adder dbsa_checker #(.WORD_BITS(WORD_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_start (word_start),
    .op_a       (op_a),
    .op_b       (op_b),
    .sum_bit    (sum_bit),
    .carry_out  (carry_out)
);

// File: tb/tb_dual_edge_serial_adder.sv
module tb_dual_edge_serial_adder;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n, word_start, op_a, op_b;
    logic sum_bit, carry_out;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic pending_carry;

    dual_edge_serial_adder #(.WORD_BITS(W)) dut (
        .clk(clk), .rst_n(rst_n), .word_start(word_start),
        .op_a(op_a), .op_b(op_b), .sum_bit(sum_bit), .carry_out(carry_out)
    );

    always #2 clk = ~clk;   // 250 MHz

    function automatic logic [W:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic check_bit(input string req, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %b exp %b at %0t", req, got, exp, $time);
        end
    endtask

    // Called at falling edge + 1. Streams one word and checks every sum bit.
    // When chk_prev is set, it checks the previous word's carry at the first
    // rising edge (R6/R7 shared edge with the R5 start clear).
    task automatic send_word(input logic [W-1:0] a, input logic [W-1:0] b, input bit chk_prev);
        logic [W:0]   exp = ref_sum(a, b);
        logic [W-1:0] got;
        for (int i = 0; i < W; i++) begin
            op_a = a[i];
            op_b = b[i];
            word_start = (i == 0);
            if (i % 2 == 0) @(posedge clk); else @(negedge clk);
            #1;
            got[i] = sum_bit;
            if (i == 0 && chk_prev) check_bit("R6 carry at shared edge", carry_out, pending_carry);
        end
        word_start = 1'b0;
        n_vec++;
        if (got !== exp[W-1:0]) begin
            n_fail++;
            $display("FAIL R2/R3/R4/R7 sum a=%0d b=%0d got %0d exp %0d", a, b, got, exp[W-1:0]);
        end
        pending_carry = exp[W];
    endtask

    // Idle cycles with random operands and no strobe; carry must stay put (R6).
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            op_a = 1'($urandom); op_b = 1'($urandom); word_start = 1'b0;
            @(posedge clk); #1;
            check_bit("R6 carry held", carry_out, pending_carry);
            op_a = 1'($urandom); op_b = 1'($urandom);
            @(negedge clk); #1;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2e3f));
        rst_n = 1'b0; word_start = 1'b0; op_a = 1'b1; op_b = 1'b1;
        // R1: reset state in both phases.
        repeat (3) @(posedge clk);
        #1;
        check_bit("R1 even sum in reset", sum_bit, 1'b0);
        check_bit("R1 carry_out in reset", carry_out, 1'b0);
        @(negedge clk); #1;
        check_bit("R1 odd sum in reset", sum_bit, 1'b0);
        rst_n = 1'b1;

        // Directed: R4 carry even->odd (1+1), odd->even (2+2), R5 clear after 15+15.
        send_word(4'd1, 4'd1, 1'b0);
        send_word(4'd2, 4'd2, 1'b1);
        send_word(4'd15, 4'd15, 1'b1);
        send_word(4'd0, 4'd0, 1'b1);     // R5: no stale carry into bit 0
        send_word(4'd15, 4'd1, 1'b1);
        idle(2);

        // R7: all 256 operand pairs back to back.
        for (int x = 0; x < 256; x++) begin
            send_word(4'(x >> 4), 4'(x), x != 0);
        end
        idle(3);

        // Random words separated by random gaps.
        for (int r = 0; r < 300; r++) begin
            int gap = $urandom_range(0, 3);
            send_word(4'($urandom), 4'($urandom), 1'b1);
            if (gap != 0) idle(gap);
        end
        idle(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule